// File: doc/BRIEF.md
# Stretchable External Memory Bus Controller

This block connects an 8-bit core with a 16-bit address space to external memory and peripherals over a multiplexed bus. The core hands over one read, write or program fetch at a time. The block runs a fixed bus cycle. An address-latch pulse first places the low address byte on the shared port. The port is then turned around to carry data, and a read, write or program-store strobe follows. A 3-bit stretch code, captured with each request, sets how long data-space strobes last. The upper four codes also add address setup ahead of the strobe and an extra hold clock after it, so that slow peripherals can be reached.

The high address byte has a port of its own and stays valid for the whole access. The shared low port is driven through a separate output-enable, and it is released whenever data is to be read. The access ends with a one-cycle `done` pulse. For reads and fetches, the data sampled at the strobe's rising edge accompanies that pulse.

The controller is a Moore state machine with six states. IDLE waits for `req_valid`. ADDR holds the latch enable high. SETUP is the address-to-strobe gap. STROBE holds the selected strobe low. HOLD keeps the address and any write data after the strobe. DONE raises `done` for one cycle. The transitions are: IDLE to ADDR when a request is accepted. ADDR to SETUP, SETUP to STROBE, STROBE to HOLD and HOLD to DONE, each when the phase timer expires. DONE to IDLE unconditionally.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset and while idle, `ale` is 0, `rd_n`, `wr_n` and `psen_n` are 1, `ad_oe` is 0 and `done` is 0.
- R2: Each access starts with exactly 2 cycles of `ale`=1. During those cycles `ad_oe`=1 and `ad_out` carries bits 7:0 of the request address.
- R3: `addr_hi` equals bits 15:8 of the accepted address in every cycle from the address phase through the `done` cycle. It changes only when a new access begins.
- R4: For data accesses, the strobe stays low for 2 cycles with stretch code 0, and for 4×code cycles with codes 1 to 7 (4, 8, …, 28).
- R5: For stretch codes 0 to 3 the strobe-setup gap after `ale` falls is 1 cycle and the post-strobe hold is 1 cycle. For codes 4 to 7 the gap is 5 cycles and the hold is 2 cycles.
- R6: On writes, `ad_oe`=1 and `ad_out` equals the write data in every cycle from `ale` falling until the end of the hold phase, which includes at least one cycle after `wr_n` rises.
- R7: On reads and fetches, `ad_oe`=0 from `ale` falling to the end of the access. `rdata` holds the value present on `ad_in` at the clock edge on which the strobe rises.
- R8: `done` is high for exactly one cycle, the cycle right after the hold phase, and `rdata` is valid in that cycle.
- R9: A program fetch (`req_fetch`=1) pulses `psen_n` low for 2 cycles with 1 setup and 1 hold cycle, whatever the stretch code. `psen_n` stays 1 at all other times.
- R10: A request arriving while an access is in progress is ignored: no new access follows the `done` pulse. The stretch code is captured at acceptance, so later changes to `stretch` do not affect the running access.
- R11: At most one of `rd_n`, `wr_n`, `psen_n` is low at a time, and none is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted only in IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = program fetch (takes precedence over req_write) |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| stretch | input | 3 | Stretch code for data accesses |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read/fetch data returned with done |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| psen_n | output | 1 | Program-store strobe, active low |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Multiplexed low address / write data |
| ad_oe | output | 1 | Drive enable for the multiplexed port |
| ad_in | input | 8 | Data read back from the multiplexed port |

## Verification
Take the clock edge that accepts a request as cycle 0. `ale` is then high in cycles 0 and 1. The setup gap, the strobe and the hold follow back to back, with lengths set by R4, R5 and R9. `done` lands exactly 2+setup+strobe+hold cycles after acceptance. The bench drives inputs and samples every output on the falling edge. It sorts each sampled cycle into a bus phase and counts the phase lengths. It compares them with lengths computed arithmetically from the stretch code. It also changes `ad_in` in the first cycle after the strobe rises, which shows that the returned data was captured on the strobe-ending edge and not later.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } ebus_state_t;
endpackage

// File: rtl/ebus_phase_len.sv
// Converts the captured stretch code and access kind into phase lengths in clocks.
module ebus_phase_len #(
    parameter int CNT_W       = 6,
    parameter int CODE_W      = 3,
    parameter int BASE_STROBE = 2,
    parameter int STEP_LOG2   = 2,
    parameter int FAST_SETUP  = 1,
    parameter int SLOW_SETUP  = 5,
    parameter int FAST_HOLD   = 1,
    parameter int SLOW_HOLD   = 2
) (
    input  logic [CODE_W-1:0] code,
    input  logic              fetch,
    output logic [CNT_W-1:0]  setup_len,
    output logic [CNT_W-1:0]  strobe_len,
    output logic [CNT_W-1:0]  hold_len
);
    localparam int SCALED_W = CODE_W + STEP_LOG2;

    logic              slow;
    logic [SCALED_W-1:0] scaled;

    always_comb begin
        slow   = code[CODE_W-1] && !fetch;
        scaled = SCALED_W'(code) << STEP_LOG2;
        setup_len = slow ? CNT_W'(SLOW_SETUP) : CNT_W'(FAST_SETUP);
        hold_len  = slow ? CNT_W'(SLOW_HOLD)  : CNT_W'(FAST_HOLD);
        if (fetch || code == '0) begin
            strobe_len = CNT_W'(BASE_STROBE);
        end else begin
            strobe_len = CNT_W'(scaled);
        end
    end
endmodule

// File: rtl/ebus_timer.sv
// Phase down-counter: loading N makes expired rise in the Nth cycle after the load.
module ebus_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int CODE_W   = 3,
    parameter int CNT_W    = 6,
    parameter int ALE_CLKS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic                   req_fetch,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [CODE_W-1:0]      stretch,
    output logic                   done,
    output logic [DATA_W-1:0]      rdata,
    output logic                   ale,
    output logic                   rd_n,
    output logic                   wr_n,
    output logic                   psen_n,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]      ad_out,
    output logic                   ad_oe,
    input  logic [DATA_W-1:0]      ad_in
);
    import ebus_pkg::*;

    localparam int HI_W = ADDR_W - DATA_W;

    ebus_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [CODE_W-1:0] code_q;
    logic              write_q;
    logic              fetch_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic [CNT_W-1:0]  setup_len, strobe_len, hold_len;
    logic              accept;
    logic              sample_rd;

    ebus_phase_len #(
        .CNT_W  (CNT_W),
        .CODE_W (CODE_W)
    ) u_len (
        .code       (code_q),
        .fetch      (fetch_q),
        .setup_len  (setup_len),
        .strobe_len (strobe_len),
        .hold_len   (hold_len)
    );

    ebus_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // Next-state and phase-timer loading
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        sample_rd = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    state_d  = ST_ADDR;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(ALE_CLKS);
                end
            end
            ST_ADDR: begin
                if (tmr_exp) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = setup_len;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = strobe_len;
                end
            end
            ST_STROBE: begin
                if (tmr_exp) begin
                    state_d   = ST_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = hold_len;
                    sample_rd = !write_q || fetch_q;
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            code_q  <= '0;
            write_q <= 1'b0;
            fetch_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                code_q  <= stretch;
                write_q <= req_write && !req_fetch;
                fetch_q <= req_fetch;
            end
            if (sample_rd) begin
                rdata_q <= ad_in;
            end
        end
    end

    // Moore outputs
    always_comb begin
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        psen_n = 1'b1;
        ad_oe  = 1'b0;
        ad_out = wdata_q;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ADDR: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr_q[DATA_W-1:0];
            end
            ST_SETUP, ST_HOLD: begin
                ad_oe = write_q;
            end
            ST_STROBE: begin
                ad_oe  = write_q;
                psen_n = !fetch_q;
                wr_n   = !write_q;
                rd_n   = write_q || fetch_q;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign addr_hi = addr_q[ADDR_W-1 -: HI_W];
    assign rdata   = rdata_q;
endmodule

// File: rtl/ebus_checker.sv
module ebus_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       psen_n,
    input logic       ad_oe,
    input logic       done,
    input logic [7:0] addr_hi
);
    assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rd_n, ~wr_n, ~psen_n}) <= 1);

    assert_no_strobe_in_ale_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && psen_n));

    assert_ale_drives_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    assert_read_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !psen_n) |-> !ad_oe);

    assert_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ad_oe);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_addr_hi_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ale) |-> $stable(addr_hi));
endmodule

bind ext_bus_ctrl ebus_checker u_ebus_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .psen_n  (psen_n),
    .ad_oe   (ad_oe),
    .done    (done),
    .addr_hi (addr_hi)
);

// File: tb/ext_bus_ctrl_test.sv
`timescale 1ns/1ps
module ext_bus_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [2:0]  stretch = '0;
    logic        done;
    logic [7:0]  rdata;
    logic        ale, rd_n, wr_n, psen_n, ad_oe;
    logic [7:0]  addr_hi, ad_out;
    logic [7:0]  ad_in = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ext_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_fetch(req_fetch), .req_addr(req_addr), .req_wdata(req_wdata),
        .stretch(stretch), .done(done), .rdata(rdata), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .psen_n(psen_n), .addr_hi(addr_hi), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_txn(input bit wr, input bit fe, input int code,
                           input logic [15:0] addr, input logic [7:0] wd,
                           input logic [7:0] rv, input bit poke);
        int  exp_set, exp_str, exp_hold;
        int  n_ale = 0, n_set = 0, n_str = 0, n_hold = 0;
        int  phase = 0;
        bit  hi_ok = 1, lo_ok = 1, dat_ok = 1, excl_ok = 1;
        bit  strobe_low;
        int  i = 0;
        exp_set  = fe ? 1 : (code >= 4 ? 5 : 1);
        exp_str  = (fe || code == 0) ? 2 : 4 * code;
        exp_hold = fe ? 1 : (code >= 4 ? 2 : 1);

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_fetch = fe;
        req_addr = addr; req_wdata = wd; stretch = 3'(code); ad_in = rv;
        @(negedge clk);
        req_valid = 1'b0;
        stretch = ~3'(code);                      // R10: later change must not matter
        while (!done && i < 200) begin
            strobe_low = fe ? !psen_n : (wr ? !wr_n : !rd_n);
            if (addr_hi != addr[15:8]) hi_ok = 0;
            if ((!rd_n) + (!wr_n) + (!psen_n) > (strobe_low ? 1 : 0)) excl_ok = 0;
            if (ale) begin
                n_ale++;
                if (!ad_oe || ad_out != addr[7:0] || !strobe_low == 0) lo_ok = 0;
            end else begin
                if (wr && (!ad_oe || ad_out != wd)) dat_ok = 0;
                if (!wr && ad_oe) dat_ok = 0;
                if (strobe_low) begin
                    n_str++; phase = 2;
                end else if (phase < 2) begin
                    n_set++;
                end else begin
                    n_hold++;
                    ad_in = ~rv;                  // R7: after the sampling edge
                end
            end
            if (poke && i == 3) begin
                req_valid = 1'b1; req_addr = ~addr; req_write = !wr;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            i++;
        end
        req_valid = 1'b0;
        chk(done == 1'b1, "R8 done reached", int'(done), 1);
        chk(n_ale == 2, "R2 ale cycles", n_ale, 2);
        chk(lo_ok, "R2 low address on port", int'(lo_ok), 1);
        chk(hi_ok, "R3 high address byte", int'(hi_ok), 1);
        if (fe) begin
            chk(n_str == exp_str, "R9 fetch strobe width", n_str, exp_str);
            chk(n_set == exp_set, "R9 fetch setup", n_set, exp_set);
            chk(n_hold == exp_hold, "R9 fetch hold", n_hold, exp_hold);
        end else begin
            chk(n_str == exp_str, "R4 strobe width", n_str, exp_str);
            chk(n_set == exp_set, "R5 setup gap", n_set, exp_set);
            chk(n_hold == exp_hold, "R5 hold", n_hold, exp_hold);
        end
        chk(excl_ok, "R11 strobe exclusivity", int'(excl_ok), 1);
        if (wr) chk(dat_ok, "R6 write data driven", int'(dat_ok), 1);
        else begin
            chk(dat_ok, "R7 port released", int'(dat_ok), 1);
            chk(rdata == rv, "R7 read data", int'(rdata), int'(rv));
        end
        @(negedge clk);
        chk(done == 1'b0, "R8 single-cycle done", int'(done), 0);
        if (poke) begin
            bit quiet = 1;
            for (int k = 0; k < 4; k++) begin
                if (ale || !rd_n || !wr_n || done) quiet = 0;
                @(negedge clk);
            end
            chk(quiet, "R10 busy request ignored", int'(quiet), 1);
            chk(addr_hi == addr[15:8], "R10 address kept", int'(addr_hi), int'(addr[15:8]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1;
        // R1: values during reset
        chk(ale == 0 && rd_n && wr_n && psen_n && !ad_oe && !done,
            "R1 reset outputs", {ale, rd_n, wr_n, psen_n, ad_oe, done}, 6'b011100);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ale == 0 && rd_n && wr_n && psen_n && !ad_oe && !done,
            "R1 idle outputs", {ale, rd_n, wr_n, psen_n, ad_oe, done}, 6'b011100);

        for (int c = 0; c < 8; c++) begin
            run_txn(1'b1, 1'b0, c, 16'h12A0 + 16'(c * 16'h0111), 8'(8'h3C + c), 8'h00, 1'b0);
            run_txn(1'b0, 1'b0, c, 16'hF00F - 16'(c * 16'h0101), 8'h00, 8'(8'hC5 ^ c), 1'b0);
            run_txn(1'b1, 1'b0, c, 16'h00FF, 8'hA5, 8'h00, 1'b0);
            run_txn(1'b0, 1'b0, c, 16'hFF00, 8'h00, 8'h5A, 1'b0);
        end
        run_txn(1'b0, 1'b1, 0, 16'h4321, 8'h00, 8'h96, 1'b0);
        run_txn(1'b0, 1'b1, 7, 16'h8765, 8'h00, 8'h69, 1'b0);
        run_txn(1'b0, 1'b0, 7, 16'hBEEF, 8'h00, 8'h77, 1'b1);
        run_txn(1'b1, 1'b0, 2, 16'hCAFE, 8'h11, 8'h00, 1'b1);

        @(negedge clk);
        chk(psen_n && rd_n && wr_n && !ad_oe, "R9 psen idle high",
            {psen_n, rd_n, wr_n, ad_oe}, 4'b1110);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule